// File: doc/BRIEF.md
# AGC Gain-Update Timing Sequencer

This block runs one automatic gain control update so that the analog and digital gain changes take effect together. A rising edge on the threshold input starts a sequence. The block samples a precomputed analog gain code and a digital gain code in that cycle. It offers the analog code to an external variable-gain amplifier controller over a valid/ready write.

Once the write is accepted, the block stages the digital code on its output. After a calibrated number of ADC output clock cycles, it pulses a one-cycle apply strobe. The converter uses that strobe to load the staged digital gain at a deterministic instant. The calibration count comes from an in-system measurement that lines the digital path latency up with the analog settling latency.

When auto-clear is enabled, the block pulses a clear request back to the threshold source once the digital gain has been applied. A threshold edge that arrives while an update is in flight is remembered. It launches the next update straight after the current strobe.

Top module: `agc_update_sequencer`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, amp_valid_o, apply_o, busy_o and thr_clr_o are low and dig_gain_o is zero.
- R2: A sequence starts only on a rising edge of thresh_i (low in the previous cycle, high in this one). amp_valid_o goes high on the next cycle, and amp_data_o carries the ana_gain_i value sampled in the edge cycle.
- R3: While amp_valid_o is high and amp_ready_i is low, amp_valid_o stays high and amp_data_o holds its value. amp_valid_o drops on the cycle after valid and ready are both high.
- R4: apply_o is high for exactly one clock per sequence.
- R5: Let the handshake cycle be the cycle in which amp_valid_o and amp_ready_i are both high, and let D be the value of delta_lat_i in that cycle. apply_o is high exactly D+1 cycles after the handshake cycle. With D equal to zero, this is the cycle right after the handshake.
- R6: dig_gain_o changes only on the cycle after a handshake. It then shows the dig_gain_i value sampled when the sequence started, and holds it through the apply strobe and afterwards.
- R7: busy_o is high from the cycle after the starting edge up to and including the apply cycle. It is low on the cycle after apply_o unless a new sequence starts then.
- R8: thr_clr_o pulses high for one cycle, on the cycle after apply_o, if auto_clr_en_i is high in the apply cycle. Otherwise it stays low.
- R9: A rising edge of thresh_i seen while a sequence is in flight, including one in the apply cycle itself, is kept pending. A new sequence then starts on the cycle after apply_o. busy_o stays high, amp_valid_o rises, and the gain codes are those sampled in the apply cycle.
- R10: thresh_i held high with no new rising edge starts no further sequence. amp_valid_o and busy_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_i | input | 1 | Threshold-crossing indication (level) |
| ana_gain_i | input | ANA_W | Precomputed analog gain code |
| dig_gain_i | input | DIG_W | Precomputed digital gain code |
| delta_lat_i | input | LAT_W | Calibrated delay, in clock cycles, from handshake to apply |
| auto_clr_en_i | input | 1 | Enables the threshold clear pulse |
| amp_valid_o | output | 1 | Amplifier write valid |
| amp_ready_i | input | 1 | Amplifier write ready |
| amp_data_o | output | ANA_W | Amplifier gain code |
| dig_gain_o | output | DIG_W | Staged digital gain code |
| apply_o | output | 1 | One-cycle digital gain apply strobe |
| busy_o | output | 1 | Update sequence in flight |
| thr_clr_o | output | 1 | Threshold clear request |

## Verification
The two functions that can fall in the same cycle are the apply strobe that ends one update and the threshold edge that launches the next. The bench provokes this in two ways. In one case it raises thresh_i in the very cycle apply_o is high. In the other it raises thresh_i earlier, during the delay wait, so the edge must be held pending. In both cases it expects amp_valid_o high on the cycle after the strobe, with busy_o never dropping. It also expects the new gain codes to be the ones present in the apply cycle, while the previous update's strobe timing and clear pulse stay intact.

// File: rtl/agc_seq_pkg.sv
package agc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WRITE = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_FIRE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/agc_trig_detect.sv
module agc_trig_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic thresh_i,
  input  logic take_i,
  output logic start_req_o
);
  logic thr_q;
  logic pend_q, pend_n;
  logic edge_w;

  assign edge_w      = thresh_i & ~thr_q;
  assign start_req_o = edge_w | pend_q;

  always_comb begin
    pend_n = pend_q;
    if (take_i)      pend_n = 1'b0;
    else if (edge_w) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      thr_q  <= thresh_i;
      pend_q <= pend_n;
    end
  end

  // R9: an edge that is not taken must still request a start next cycle
  p_no_lost_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && !take_i) |=> start_req_o);
endmodule

// File: rtl/agc_lat_counter.sv
module agc_lat_counter #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             expire_o
);
  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [LAT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i)    cnt_n = load_val_i;
    else if (en_i) cnt_n = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expire_o = (cnt_q == ONE);

  // R5: the wait never runs on an empty count
  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q != '0));
endmodule

// File: rtl/agc_update_sequencer.sv
module agc_update_sequencer
  import agc_seq_pkg::*;
#(
  parameter int ANA_W = 6,
  parameter int DIG_W = 14,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thresh_i,
  input  logic [ANA_W-1:0] ana_gain_i,
  input  logic [DIG_W-1:0] dig_gain_i,
  input  logic [LAT_W-1:0] delta_lat_i,
  input  logic             auto_clr_en_i,
  output logic             amp_valid_o,
  input  logic             amp_ready_i,
  output logic [ANA_W-1:0] amp_data_o,
  output logic [DIG_W-1:0] dig_gain_o,
  output logic             apply_o,
  output logic             busy_o,
  output logic             thr_clr_o
);
  seq_state_e       state_q, state_n;
  logic             start_req, take, ack, expire, zero_delta;
  logic [ANA_W-1:0] ana_q;
  logic [DIG_W-1:0] dig_stage_q, dig_out_q;
  logic             clr_q;

  agc_trig_detect u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .thresh_i   (thresh_i),
    .take_i     (take),
    .start_req_o(start_req)
  );

  agc_lat_counter #(.LAT_W(LAT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ack && !zero_delta),
    .load_val_i(delta_lat_i),
    .en_i      (state_q == SEQ_WAIT),
    .expire_o  (expire)
  );

  assign zero_delta = (delta_lat_i == '0);
  assign ack  = (state_q == SEQ_WRITE) && amp_ready_i;
  assign take = start_req && ((state_q == SEQ_IDLE) || (state_q == SEQ_FIRE));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (start_req) state_n = SEQ_WRITE;
      SEQ_WRITE: if (amp_ready_i) state_n = zero_delta ? SEQ_FIRE : SEQ_WAIT;
      SEQ_WAIT:  if (expire) state_n = SEQ_FIRE;
      SEQ_FIRE:  state_n = start_req ? SEQ_WRITE : SEQ_IDLE;
      default:   state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      ana_q       <= '0;
      dig_stage_q <= '0;
      dig_out_q   <= '0;
      clr_q       <= 1'b0;
    end else begin
      state_q <= state_n;
      clr_q   <= (state_q == SEQ_FIRE) && auto_clr_en_i;
      if (take) begin
        ana_q       <= ana_gain_i;
        dig_stage_q <= dig_gain_i;
      end
      if (ack) dig_out_q <= dig_stage_q;
    end
  end

  assign amp_valid_o = (state_q == SEQ_WRITE);
  assign amp_data_o  = ana_q;
  assign dig_gain_o  = dig_out_q;
  assign apply_o     = (state_q == SEQ_FIRE);
  assign busy_o      = (state_q != SEQ_IDLE);
  assign thr_clr_o   = clr_q;

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |=> !apply_o);
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid_o && !amp_ready_i) |=> (amp_valid_o && $stable(amp_data_o)));
  p_zero_delta_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid_o && amp_ready_i && delta_lat_i == '0) |=> apply_o);
  p_dig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(amp_valid_o && amp_ready_i) |=> $stable(dig_gain_o));
  p_busy_at_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |-> busy_o);
  p_clr_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_o && auto_clr_en_i) |=> thr_clr_o);
  p_clr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_clr_o |-> $past(apply_o));
endmodule

// File: tb/agc_update_sequencer_tb_top.sv
module agc_update_sequencer_tb_top;
  localparam int ANA_W = 6;
  localparam int DIG_W = 14;
  localparam int LAT_W = 8;

  typedef struct packed {
    logic [LAT_W-1:0] delta;
    logic [ANA_W-1:0] ana;
    logic [DIG_W-1:0] dig;
    logic [3:0]       lag;
    logic             aclr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{delta: 8'd0,  ana: 6'h15, dig: 14'h1a2b, lag: 4'd0, aclr: 1'b1},
    '{delta: 8'd1,  ana: 6'h2a, dig: 14'h0f0f, lag: 4'd2, aclr: 1'b0},
    '{delta: 8'd5,  ana: 6'h3f, dig: 14'h3fff, lag: 4'd0, aclr: 1'b1},
    '{delta: 8'd12, ana: 6'h01, dig: 14'h0001, lag: 4'd5, aclr: 1'b1},
    '{delta: 8'd0,  ana: 6'h20, dig: 14'h2000, lag: 4'd3, aclr: 1'b0},
    '{delta: 8'd2,  ana: 6'h0c, dig: 14'h1234, lag: 4'd1, aclr: 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             thresh;
  logic [ANA_W-1:0] ana_gain;
  logic [DIG_W-1:0] dig_gain;
  logic [LAT_W-1:0] delta_lat;
  logic             auto_clr;
  logic             amp_valid, amp_ready;
  logic [ANA_W-1:0] amp_data;
  logic [DIG_W-1:0] dig_out;
  logic             apply, busy, thr_clr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  agc_update_sequencer #(.ANA_W(ANA_W), .DIG_W(DIG_W), .LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .thresh_i(thresh), .ana_gain_i(ana_gain),
    .dig_gain_i(dig_gain), .delta_lat_i(delta_lat), .auto_clr_en_i(auto_clr),
    .amp_valid_o(amp_valid), .amp_ready_i(amp_ready), .amp_data_o(amp_data),
    .dig_gain_o(dig_out), .apply_o(apply), .busy_o(busy), .thr_clr_o(thr_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Wait for the handshake, then follow the delay, the strobe and the clear.
  task automatic finish_seq(input vec_t v, input bit pend_edge);
    logic [31:0] bad = 0;
    for (int i = 0; i < int'(v.lag); i++) begin
      tick();
      if (!(amp_valid && amp_data == v.ana)) bad++;
    end
    check("R3 valid and data held while not ready", bad, 0);
    amp_ready = 1'b1;
    delta_lat = v.delta;
    auto_clr  = v.aclr;
    tick();
    amp_ready = 1'b0;
    check("R3 valid drops after handshake", {31'd0, amp_valid}, 0);
    check("R6 staged digital gain", {18'd0, dig_out}, {18'd0, v.dig});
    bad = 0;
    for (int j = 0; j <= int'(v.delta); j++) begin
      if (pend_edge && j == 1) thresh = 1'b1;
      if (apply !== (j == int'(v.delta))) bad++;
      if (!busy) bad++;
      if (j != int'(v.delta)) tick();
    end
    check("R5 R7 strobe at delta+1 after handshake", bad, 0);
    tick();
    check("R4 strobe one cycle wide", {31'd0, apply}, 0);
    check("R8 clear pulse follows strobe", {31'd0, thr_clr}, {31'd0, v.aclr});
  endtask

  task automatic start_seq(input vec_t v);
    ana_gain = v.ana;
    dig_gain = v.dig;
    thresh   = 1'b1;
    tick();
    check("R2 valid after edge", {31'd0, amp_valid}, 1);
    check("R2 captured analog code", {26'd0, amp_data}, {26'd0, v.ana});
    check("R7 busy after edge", {31'd0, busy}, 1);
    thresh   = 1'b0;
    ana_gain = ~v.ana;
    dig_gain = ~v.dig;
  endtask

  initial begin
    rst_n = 1'b0; thresh = 1'b0; ana_gain = '0; dig_gain = '0;
    delta_lat = '0; auto_clr = 1'b0; amp_ready = 1'b0;
    repeat (3) tick();
    check("R1 reset outputs", {amp_valid, apply, busy, thr_clr}, 0);
    rst_n = 1'b1;
    tick();
    check("R1 first cycle after reset", {amp_valid, apply, busy, thr_clr}, 0);
    check("R1 digital gain reset", {18'd0, dig_out}, 0);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      start_seq(VEC[k]);
      finish_seq(VEC[k], 1'b0);
      check("R7 busy low after strobe", {31'd0, busy}, 0);
      tick();
      check("R8 clear one cycle", {31'd0, thr_clr}, 0);
    end

    // R10: a level held high starts only one sequence
    begin
      logic [31:0] bad = 0;
      vec_t v = '{delta: 8'd1, ana: 6'h07, dig: 14'h0777, lag: 4'd0, aclr: 1'b0};
      start_seq(v);
      thresh = 1'b1;
      finish_seq(v, 1'b0);
      for (int i = 0; i < 10; i++) begin
        tick();
        if (amp_valid || busy) bad++;
      end
      check("R10 held level gives no restart", bad, 0);
      thresh = 1'b0;
      tick();
    end

    // R9: edge during the wait is held pending
    begin
      vec_t v = '{delta: 8'd4, ana: 6'h11, dig: 14'h0111, lag: 4'd1, aclr: 1'b1};
      vec_t w = '{delta: 8'd0, ana: 6'h22, dig: 14'h0222, lag: 4'd0, aclr: 1'b0};
      start_seq(v);
      ana_gain = w.ana;
      dig_gain = w.dig;
      finish_seq(v, 1'b1);
      check("R9 pending edge restarts", {31'd0, amp_valid}, 1);
      check("R9 busy held", {31'd0, busy}, 1);
      check("R9 new analog code", {26'd0, amp_data}, {26'd0, w.ana});
      thresh = 1'b0;
      finish_seq(w, 1'b0);
      check("R9 second digital gain kept", {18'd0, dig_out}, {18'd0, w.dig});
    end

    // R9: edge in the apply cycle itself
    begin
      vec_t v = '{delta: 8'd2, ana: 6'h33, dig: 14'h0333, lag: 4'd0, aclr: 1'b0};
      vec_t w = '{delta: 8'd1, ana: 6'h04, dig: 14'h0444, lag: 4'd0, aclr: 1'b1};
      start_seq(v);
      amp_ready = 1'b1;
      delta_lat = v.delta;
      tick();
      amp_ready = 1'b0;
      tick();
      tick();
      check("R5 strobe for coincident case", {31'd0, apply}, 1);
      thresh   = 1'b1;
      ana_gain = w.ana;
      dig_gain = w.dig;
      tick();
      check("R9 coincident edge restarts", {31'd0, amp_valid}, 1);
      check("R9 coincident busy", {31'd0, busy}, 1);
      check("R9 coincident analog code", {26'd0, amp_data}, {26'd0, w.ana});
      thresh = 1'b0;
      finish_seq(w, 1'b0);
    end

    // R1: reset in the middle of a wait
    begin
      vec_t v = '{delta: 8'd9, ana: 6'h3a, dig: 14'h0aaa, lag: 4'd0, aclr: 1'b1};
      start_seq(v);
      amp_ready = 1'b1;
      delta_lat = v.delta;
      tick();
      amp_ready = 1'b0;
      tick();
      rst_n = 1'b0;
      tick();
      check("R1 mid-sequence reset", {amp_valid, apply, busy, thr_clr}, 0);
      rst_n = 1'b1;
      repeat (12) tick();
      check("R1 no strobe after reset", {apply, busy}, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule